// File: doc/BRIEF.md
# Machine Control and Status Register Bank

This block is the control and status register bank of a 32-bit integer core. Each cycle in which the access strobe is high, the bank decodes a 12-bit register address and one of six read-modify-write operations. It returns the register's previous contents in the same cycle, for the destination register, and commits the new contents on the next clock edge. The operations are swap, bit-set and bit-clear, each with a register-operand form and a 5-bit immediate form.

The bank holds the following registers:
- the trap vector, the trap return address, the trap cause and the faulting address;
- a status word and two scratch words;
- a constant thread identifier;
- an outbound and an inbound mailbox for a host;
- three free-running 64-bit counters (clock cycles, timer ticks and retired instructions), each read as two 32-bit halves.

A dedicated load port lets the trap sequencer write the return address, cause and faulting address directly. The outbound mailbox drives a small two-state machine. It stays in `HO_IDLE` until a committed write to the mailbox moves it to `HO_PULSE`. It stays in `HO_PULSE` for as long as such writes continue, and returns to `HO_IDLE` on the first cycle without one. `host_out_valid` is high exactly while the machine is in `HO_PULSE`.

Top module: `csr_bank`

## Requirements
- R1: Op code 3'b001 (swap) returns the register's old value on `rd_data` in the access cycle, and the register holds `acc_src` from the next edge on.
- R2: Op code 3'b010 ORs the operand into the register, and op code 3'b011 ANDs the register with the inverted operand. Both return the old value.
- R3: Op codes 3'b101, 3'b110 and 3'b111 behave like 3'b001, 3'b010 and 3'b011, but use `acc_imm` zero-extended to 32 bits and ignore `acc_src`.
- R4: The address map is: scratch 0x500 and 0x501, return address 0x502, faulting address 0x503, trap vector 0x508, cause 0x509, status 0x50a, thread ID 0x50b, outbound mailbox 0x51e, inbound mailbox 0x51f. Each writable entry reads back what was last written to it.
- R5: The thread ID (0x50b) reads as the `HART_ID` parameter. It and all six counter addresses are read-only, and writes to them change nothing.
- R6: An access to any other address returns zero, raises `illegal` during the access cycle, and changes no state.
- R7: The counters sit at 0xc00/0xc80 (cycles, low/high), 0xc01/0xc81 (ticks, low/high) and 0xc02/0xc82 (retired, low/high). The cycle counter adds one at every edge after reset, the tick counter at each edge with `tick` high, and the retired counter at each edge with `retire` high.
- R8: A committed write to 0x51e raises `host_out_valid` for the cycle after the write edge, with `host_out_data` carrying the written value. It is low otherwise.
- R9: Set or clear with a zero operand, and op codes 3'b000 and 3'b100, perform no write. In particular, they raise no outbound mailbox strobe.
- R10: `exc_load` loads `exc_epc`, `exc_cause` and `exc_badaddr` into 0x502, 0x509 and 0x503, and wins over a CSR write to those registers in the same cycle.
- R11: `host_in_valid` loads `host_in_data` into 0x51f, and wins over a CSR write to 0x51f in the same cycle.
- R12: Reset (`rst_n` low, asynchronous) clears every register and counter to zero, except the trap vector, which takes `EVEC_RESET`. `host_out_valid` is low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_addr | input | 12 | Register address |
| acc_op | input | 3 | Operation code |
| acc_src | input | 32 | Register operand |
| acc_imm | input | 5 | Immediate operand |
| rd_data | output | 32 | Old register value |
| illegal | output | 1 | Unmapped address accessed |
| tick | input | 1 | Timer tick |
| retire | input | 1 | Instruction retired |
| exc_load | input | 1 | Load trap registers |
| exc_epc | input | 32 | Trap return address to load |
| exc_cause | input | 32 | Trap cause to load |
| exc_badaddr | input | 32 | Faulting address to load |
| host_in_valid | input | 1 | Inbound mailbox load |
| host_in_data | input | 32 | Inbound mailbox data |
| host_out_valid | output | 1 | Outbound mailbox strobe |
| host_out_data | output | 32 | Outbound mailbox data |
| evec_o | output | 32 | Current trap vector |
| epc_o | output | 32 | Current return address |
| status_o | output | 32 | Current status word |

## Verification
A wrong stored value in this bank shows on `rd_data` at the very next read of that address. Because every access returns the old value, a swap, set or clear on a corrupted register exposes the corruption in the same cycle, before the new value lands. A stuck or skipped counter increment shows as a difference between a low half and the bench's own count of cycles, ticks or retire pulses. A wrong mailbox state shows one cycle after the write edge, as a missing, extra or stretched `host_out_valid` pulse.

// File: rtl/csr_pkg.sv
package csr_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'b000,
        OP_WR    = 3'b001,
        OP_SET   = 3'b010,
        OP_CLR   = 3'b011,
        OP_NONEI = 3'b100,
        OP_WRI   = 3'b101,
        OP_SETI  = 3'b110,
        OP_CLRI  = 3'b111
    } csr_op_e;

    typedef enum logic {HO_IDLE, HO_PULSE} host_st_e;

    localparam logic [11:0] A_SCR0  = 12'h500;
    localparam logic [11:0] A_SCR1  = 12'h501;
    localparam logic [11:0] A_EPC   = 12'h502;
    localparam logic [11:0] A_BAD   = 12'h503;
    localparam logic [11:0] A_EVEC  = 12'h508;
    localparam logic [11:0] A_CAUSE = 12'h509;
    localparam logic [11:0] A_STAT  = 12'h50a;
    localparam logic [11:0] A_HART  = 12'h50b;
    localparam logic [11:0] A_TOH   = 12'h51e;
    localparam logic [11:0] A_FROMH = 12'h51f;

    localparam int NCTR = 3;
    localparam logic [11:0] CTR_LO_BASE = 12'hc00;
    localparam logic [11:0] CTR_HI_BASE = 12'hc80;
endpackage

// File: rtl/csr_alu.sv
module csr_alu #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 5
) (
    input  logic [2:0]       op,
    input  logic [XLEN-1:0]  src,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  old_val,
    output logic [XLEN-1:0]  new_val,
    output logic             wr_req
);
    logic [XLEN-1:0] operand;

    always_comb begin
        operand = op[2] ? {{(XLEN-IMM_W){1'b0}}, imm} : src;
        unique case (op[1:0])
            2'b01: begin new_val = operand;            wr_req = 1'b1; end
            2'b10: begin new_val = old_val | operand;  wr_req = (operand != '0); end
            2'b11: begin new_val = old_val & ~operand; wr_req = (operand != '0); end
            default: begin new_val = old_val;          wr_req = 1'b0; end
        endcase
    end
endmodule

// File: rtl/csr_ctr64.sv
module csr_ctr64 #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= '0;
        else if (inc) value <= value + 1'b1;
    end

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> value == $past(value) + 1'b1); // R7
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(value)); // R7
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          IMM_W      = 5,
    parameter logic [31:0] HART_ID    = 32'h0,
    parameter logic [31:0] EVEC_RESET = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic [11:0]      acc_addr,
    input  logic [2:0]       acc_op,
    input  logic [XLEN-1:0]  acc_src,
    input  logic [IMM_W-1:0] acc_imm,
    output logic [XLEN-1:0]  rd_data,
    output logic             illegal,
    input  logic             tick,
    input  logic             retire,
    input  logic             exc_load,
    input  logic [XLEN-1:0]  exc_epc,
    input  logic [XLEN-1:0]  exc_cause,
    input  logic [XLEN-1:0]  exc_badaddr,
    input  logic             host_in_valid,
    input  logic [XLEN-1:0]  host_in_data,
    output logic             host_out_valid,
    output logic [XLEN-1:0]  host_out_data,
    output logic [XLEN-1:0]  evec_o,
    output logic [XLEN-1:0]  epc_o,
    output logic [XLEN-1:0]  status_o
);
    localparam int CTR_W = 2 * XLEN;

    logic [XLEN-1:0] scr0_q, scr1_q, epc_q, bad_q, evec_q, cause_q, stat_q, toh_q, fromh_q;
    logic [CTR_W-1:0] ctr_val [NCTR];
    logic [NCTR-1:0]  ctr_inc;
    logic [XLEN-1:0]  rd_val, new_val;
    logic             hit, ro, alu_wr, wr_go, wr_toh;
    host_st_e         host_st, host_nx;

    assign ctr_inc = {retire, tick, 1'b1};

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        csr_ctr64 #(.W(CTR_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .inc(ctr_inc[g]), .value(ctr_val[g])
        );
    end

    // Read mux and address decode
    always_comb begin
        rd_val = '0;
        hit    = 1'b1;
        ro     = 1'b0;
        case (acc_addr)
            A_SCR0:  rd_val = scr0_q;
            A_SCR1:  rd_val = scr1_q;
            A_EPC:   rd_val = epc_q;
            A_BAD:   rd_val = bad_q;
            A_EVEC:  rd_val = evec_q;
            A_CAUSE: rd_val = cause_q;
            A_STAT:  rd_val = stat_q;
            A_TOH:   rd_val = toh_q;
            A_FROMH: rd_val = fromh_q;
            A_HART:  begin rd_val = HART_ID; ro = 1'b1; end
            default: begin
                hit = 1'b0;
                for (int i = 0; i < NCTR; i++) begin
                    if (acc_addr == CTR_LO_BASE + 12'(i)) begin
                        rd_val = ctr_val[i][XLEN-1:0];
                        hit = 1'b1;
                        ro  = 1'b1;
                    end
                    if (acc_addr == CTR_HI_BASE + 12'(i)) begin
                        rd_val = ctr_val[i][CTR_W-1:XLEN];
                        hit = 1'b1;
                        ro  = 1'b1;
                    end
                end
            end
        endcase
    end

    assign rd_data = rd_val;
    assign illegal = acc_en && !hit;

    csr_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
        .op(acc_op), .src(acc_src), .imm(acc_imm), .old_val(rd_val),
        .new_val(new_val), .wr_req(alu_wr)
    );

    assign wr_go  = acc_en && hit && !ro && alu_wr;
    assign wr_toh = wr_go && (acc_addr == A_TOH);

    // Register file; trap load and host input take priority over CSR writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scr0_q  <= '0;
            scr1_q  <= '0;
            epc_q   <= '0;
            bad_q   <= '0;
            evec_q  <= EVEC_RESET;
            cause_q <= '0;
            stat_q  <= '0;
            toh_q   <= '0;
            fromh_q <= '0;
        end else begin
            if (wr_go) begin
                case (acc_addr)
                    A_SCR0:  scr0_q  <= new_val;
                    A_SCR1:  scr1_q  <= new_val;
                    A_EPC:   epc_q   <= new_val;
                    A_BAD:   bad_q   <= new_val;
                    A_EVEC:  evec_q  <= new_val;
                    A_CAUSE: cause_q <= new_val;
                    A_STAT:  stat_q  <= new_val;
                    A_TOH:   toh_q   <= new_val;
                    A_FROMH: fromh_q <= new_val;
                    default: ;
                endcase
            end
            if (exc_load) begin
                epc_q   <= exc_epc;
                cause_q <= exc_cause;
                bad_q   <= exc_badaddr;
            end
            if (host_in_valid) fromh_q <= host_in_data;
        end
    end

    // Outbound mailbox strobe: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_st <= HO_IDLE;
        else        host_st <= host_nx;
    end

    // Outbound mailbox strobe: next state and outputs
    always_comb begin
        unique case (host_st)
            HO_IDLE:  host_nx = wr_toh ? HO_PULSE : HO_IDLE;
            HO_PULSE: host_nx = wr_toh ? HO_PULSE : HO_IDLE;
            default:  host_nx = HO_IDLE;
        endcase
        host_out_valid = (host_st == HO_PULSE);
        host_out_data  = toh_q;
    end

    assign evec_o   = evec_q;
    assign epc_o    = epc_q;
    assign status_o = stat_q;

    AST_TOHOST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr == A_TOH && acc_op == OP_WR)
        |=> host_out_valid && host_out_data == $past(acc_src)); // R8
    AST_ZERO_SET_NOSTRB: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr == A_TOH && acc_op == OP_SET && acc_src == '0)
        |=> !host_out_valid); // R9
    AST_UNMAPPED_NOSTRB: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !host_out_valid); // R6
    AST_EXC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_load |=> epc_o == $past(exc_epc)); // R10
    AST_EVEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && acc_addr == A_EVEC) |=> $stable(evec_o)); // R4
endmodule

// File: tb/csr_bank_bench.sv
`timescale 1ns/1ps
module csr_bank_bench;
    import csr_pkg::*;

    localparam logic [31:0] HART = 32'hA5A5_0001;
    localparam logic [31:0] EVR  = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [2:0]  acc_op = '0;
    logic [31:0] acc_src = '0;
    logic [4:0]  acc_imm = '0;
    logic [31:0] rd_data;
    logic        illegal;
    logic        tick = 1'b0, retire = 1'b0, exc_load = 1'b0, host_in_valid = 1'b0;
    logic [31:0] exc_epc = '0, exc_cause = '0, exc_badaddr = '0, host_in_data = '0;
    logic        host_out_valid;
    logic [31:0] host_out_data, evec_o, epc_o, status_o;

    always #2.5 clk = ~clk;

    csr_bank #(.HART_ID(HART), .EVEC_RESET(EVR)) u_csr_bank (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_addr(acc_addr),
        .acc_op(acc_op), .acc_src(acc_src), .acc_imm(acc_imm),
        .rd_data(rd_data), .illegal(illegal), .tick(tick), .retire(retire),
        .exc_load(exc_load), .exc_epc(exc_epc), .exc_cause(exc_cause),
        .exc_badaddr(exc_badaddr), .host_in_valid(host_in_valid),
        .host_in_data(host_in_data), .host_out_valid(host_out_valid),
        .host_out_data(host_out_data), .evec_o(evec_o), .epc_o(epc_o),
        .status_o(status_o)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] rd;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // Bench-side reference counts
    logic [31:0] cyc_cnt = '0, tk_cnt = '0, rt_cnt = '0;
    always @(posedge clk) begin
        if (rst_n) begin
            cyc_cnt <= cyc_cnt + 1;
            if (tick)   tk_cnt <= tk_cnt + 1;
            if (retire) rt_cnt <= rt_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr_pulses();
        acc_en = 1'b0; tick = 1'b0; retire = 1'b0; exc_load = 1'b0; host_in_valid = 1'b0;
    endtask

    // Driver: one access per cycle, expected result pushed to the scoreboard
    task automatic acc(input logic [11:0] a, input logic [2:0] op, input logic [31:0] s,
                       input logic [4:0] im, input logic [31:0] exp, input bit ill,
                       input bit use_cyc, input string tag);
        exp_t e;
        @(posedge clk); #1;
        clr_pulses();
        acc_en = 1'b1; acc_addr = a; acc_op = op; acc_src = s; acc_imm = im;
        e.rd = use_cyc ? cyc_cnt : exp;
        e.ill = ill;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        clr_pulses();
    endtask

    // Monitor: compare each access at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (acc_en) begin
                exp_t e;
                if (sb.size() == 0) begin
                    chk(1'b0, "scoreboard empty", rd_data, 32'h0);
                end else begin
                    e = sb.pop_front();
                    chk(rd_data === e.rd, {e.tag, " rd_data"}, rd_data, e.rd);
                    chk(illegal === e.ill, {e.tag, " illegal"}, {31'b0, illegal}, {31'b0, e.ill});
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(evec_o == EVR, "R12 evec reset", evec_o, EVR);
        chk(status_o == 0, "R12 status reset", status_o, 0);
        chk(host_out_valid == 0, "R12 strobe reset", {31'b0, host_out_valid}, 0);
        rst_n = 1'b1;

        acc(A_EVEC, OP_NONE, 0, 0, EVR, 0, 0, "R12 evec read");
        acc(A_CAUSE, OP_NONE, 0, 0, 0, 0, 0, "R12 cause read");
        acc(A_FROMH, OP_NONE, 0, 0, 0, 0, 0, "R12 fromhost read");

        // R1 swap
        acc(A_EPC, OP_WR, 32'h1234_5678, 0, 0, 0, 0, "R1 swap old");
        acc(A_EPC, OP_NONE, 0, 0, 32'h1234_5678, 0, 0, "R1 swap readback");
        idle();
        chk(epc_o == 32'h1234_5678, "R1 epc_o", epc_o, 32'h1234_5678);

        // R2 set / clear
        acc(A_STAT, OP_SET, 32'hF0, 0, 0, 0, 0, "R2 set old");
        acc(A_STAT, OP_CLR, 32'h30, 0, 32'hF0, 0, 0, "R2 clear old");
        acc(A_STAT, OP_NONE, 0, 0, 32'hC0, 0, 0, "R2 result");

        // R3 immediate forms
        acc(A_SCR0, OP_WRI, 32'hFFFF_FFFF, 5'h1F, 0, 0, 0, "R3 wri old");
        acc(A_SCR0, OP_CLRI, 32'hFFFF_FFFF, 5'h03, 32'h1F, 0, 0, "R3 clri old");
        acc(A_SCR1, OP_SETI, 32'hFFFF_0000, 5'h05, 0, 0, 0, "R3 seti old");
        acc(A_SCR1, OP_NONE, 0, 0, 32'h5, 0, 0, "R3 seti result");
        acc(A_SCR0, OP_NONE, 0, 0, 32'h1C, 0, 0, "R3 clri result");

        // R4 map
        acc(A_BAD, OP_WR, 32'hDEAD_BEEF, 0, 0, 0, 0, "R4 bad write");
        acc(A_CAUSE, OP_WR, 32'h7, 0, 0, 0, 0, "R4 cause write");
        acc(A_EVEC, OP_WR, 32'h2000, 0, EVR, 0, 0, "R4 evec write");
        acc(A_BAD, OP_NONE, 0, 0, 32'hDEAD_BEEF, 0, 0, "R4 bad read");
        acc(A_CAUSE, OP_NONE, 0, 0, 32'h7, 0, 0, "R4 cause read");
        acc(A_EVEC, OP_NONE, 0, 0, 32'h2000, 0, 0, "R4 evec read");

        // R5 read-only
        acc(A_HART, OP_WR, 32'h0, 0, HART, 0, 0, "R5 hart write");
        acc(A_HART, OP_NONE, 0, 0, HART, 0, 0, "R5 hart read");
        acc(12'hc80, OP_WR, 32'hFFFF, 0, 0, 0, 0, "R5 cycleh write");
        acc(12'hc80, OP_NONE, 0, 0, 0, 0, 0, "R5 cycleh read");

        // R7 counters
        for (int i = 0; i < 5; i++) begin
            idle();
            tick = (i != 1);
            retire = (i >= 3);
        end
        idle();
        acc(12'hc01, OP_NONE, 0, 0, 32'd4, 0, 0, "R7 ticks low");
        acc(12'hc02, OP_NONE, 0, 0, 32'd2, 0, 0, "R7 retired low");
        acc(12'hc00, OP_NONE, 0, 0, 0, 0, 1, "R7 cycles low");
        acc(12'hc81, OP_NONE, 0, 0, 0, 0, 0, "R7 ticks high");
        acc(12'hc01, OP_WR, 32'h0, 0, 32'd4, 0, 0, "R5 ticks write");
        acc(12'hc01, OP_NONE, 0, 0, 32'd4, 0, 0, "R5 ticks unchanged");
        acc(12'hc00, OP_NONE, 0, 0, 0, 0, 1, "R7 cycles advance");

        // R8 outbound strobe
        acc(A_TOH, OP_WR, 32'hCAFE_0001, 0, 0, 0, 0, "R8 tohost write");
        idle();
        chk(host_out_valid == 1, "R8 strobe high", {31'b0, host_out_valid}, 1);
        chk(host_out_data == 32'hCAFE_0001, "R8 strobe data", host_out_data, 32'hCAFE_0001);
        idle();
        chk(host_out_valid == 0, "R8 strobe one cycle", {31'b0, host_out_valid}, 0);

        // R9 no-write operations
        acc(A_TOH, OP_SET, 32'h0, 0, 32'hCAFE_0001, 0, 0, "R9 set zero");
        idle();
        chk(host_out_valid == 0, "R9 set zero no strobe", {31'b0, host_out_valid}, 0);
        acc(A_TOH, OP_CLRI, 32'hFFFF_FFFF, 5'h0, 32'hCAFE_0001, 0, 0, "R9 clri zero");
        acc(A_TOH, OP_NONEI, 32'hFFFF_FFFF, 5'h1F, 32'hCAFE_0001, 0, 0, "R9 op100");
        idle();
        chk(host_out_valid == 0, "R9 op100 no strobe", {31'b0, host_out_valid}, 0);

        // R11 inbound mailbox
        idle();
        host_in_valid = 1'b1; host_in_data = 32'h55;
        acc(A_FROMH, OP_NONE, 0, 0, 32'h55, 0, 0, "R11 fromhost load");
        acc(A_FROMH, OP_WR, 32'h77, 0, 32'h55, 0, 0, "R11 conflict old");
        host_in_valid = 1'b1; host_in_data = 32'h99;
        acc(A_FROMH, OP_NONE, 0, 0, 32'h99, 0, 0, "R11 host wins");

        // R10 trap load port
        acc(A_EPC, OP_WR, 32'h999, 0, 32'h1234_5678, 0, 0, "R10 conflict old");
        exc_load = 1'b1; exc_epc = 32'h400; exc_cause = 32'h8000_000B; exc_badaddr = 32'h44;
        acc(A_EPC, OP_NONE, 0, 0, 32'h400, 0, 0, "R10 epc load wins");
        acc(A_CAUSE, OP_NONE, 0, 0, 32'h8000_000B, 0, 0, "R10 cause load");
        acc(A_BAD, OP_NONE, 0, 0, 32'h44, 0, 0, "R10 badaddr load");

        // R6 unmapped
        acc(12'h7FF, OP_NONE, 0, 0, 0, 1, 0, "R6 unmapped read");
        acc(12'h504, OP_WR, 32'hFFFF, 0, 0, 1, 0, "R6 unmapped write");
        idle();
        chk(host_out_valid == 0, "R6 no strobe", {31'b0, host_out_valid}, 0);
        acc(A_SCR0, OP_NONE, 0, 0, 32'h1C, 0, 0, "R6 scratch untouched");
        acc(A_STAT, OP_NONE, 0, 0, 32'hC0, 0, 0, "R6 status untouched");
        idle();
        idle();

        chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule